// File: doc/BRIEF.md
# Dual-Copy Clock Register Front End

This block sits between a byte-oriented host bus and a real-time counter. It holds two copies of the eight timekeeping bytes. The internal copy is loaded by the counter logic outside the block. The user copy is what the host reads. On each update tick, all eight internal bytes move into the user copy on the same clock edge. The host therefore never sees a partly updated time.

The host sets a byte pointer, opens a read or write transaction, and moves bytes one at a time. The pointer steps forward after every byte. A read transaction that points into the clock range freezes the user copy, so a burst read returns one consistent time. Ticks that arrive while the copy is frozen are remembered and applied once the freeze lifts.

A power-fail input sets a sticky halt flag. The flag stops all transfers, so the user copy keeps the time at which power failed. Software clears the flag through the bus. A write to a clock byte updates both copies and sends a one-cycle reset pulse to the external divider chain.

Top module: `clkreg_shadow_ctrl`

## Requirements
- R1: After reset the pointer is 00h, the halt flag, hold indication, divider-reset pulse and read data are 0, and every stored byte is 0.
- R2: An update tick, with no hold and no halt, copies all eight internal bytes (00h–07h) into the user copy on one edge. Reads then return the copied values.
- R3: A pointer load takes the bus address, or 00h if that address is above 13h. Each byte read or written advances the pointer by one, and the step after 13h gives 00h.
- R4: While a read transaction is open and the pointer is in 00h–07h, `hold_active` is 1 and ticks do not change the user copy. A write transaction never raises the hold.
- R5: The hold ends at a bus stop, or when the pointer advances to 08h or beyond. A tick received during the hold is applied exactly once after it ends.
- R6: A power-fail pulse sets the halt flag. The flag is read as bit 6 of register 0Ch. While it is set, ticks leave the user copy unchanged. Power-fail wins over a simultaneous write that would clear the flag.
- R7: Writing 0 to bit 6 of 0Ch clears the halt flag. A tick held back during the halt is then transferred, and the user copy shows the current internal time.
- R8: A write to 00h–07h updates that byte in both copies. `int_time` byte n sits at bits [8n+7:8n]. `div_rst` is high for the single cycle after the write edge.
- R9: Registers 08h–13h are plain byte storage that can be written and read back, including the control byte at 08h on its own. Writes there do not pulse `div_rst`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr_ld | input | 1 | Load pointer from bus_addr |
| bus_addr | input | 5 | Register address to load |
| bus_start | input | 1 | Open a transaction |
| bus_rnw | input | 1 | Transaction direction at start, 1 = read |
| bus_stop | input | 1 | Close the transaction |
| bus_wr | input | 1 | Write one byte at the pointer |
| bus_wdata | input | 8 | Write byte |
| bus_rd | input | 1 | Read one byte at the pointer |
| rd_data | output | 8 | Byte read, valid the cycle after bus_rd |
| ptr | output | 5 | Current pointer |
| upd_tick | input | 1 | Update request from the counter |
| cnt_load | input | 1 | Load internal copy from cnt_next |
| cnt_next | input | 64 | Incremented time from the counter |
| int_time | output | 64 | Internal copy, byte n at [8n+7:8n] |
| pwr_fail | input | 1 | Power-fail event |
| halt_flag | output | 1 | Halt-update flag |
| hold_active | output | 1 | Transfers held off by a clock-range read |
| div_rst | output | 1 | One-cycle divider-reset pulse |

## Verification
The bench uses the default build: 20 registers, eight clock bytes, and the halt flag at bit 6 of 0Ch. With 20 registers, the pointer wrap at 13h and the rejection of an out-of-range load address can both be reached in a few bytes. With eight clock bytes, the exit of a burst read from the clock range at 08h releases a held tick. Distinct byte patterns are loaded into the internal copy at each phase. This shows whether a read returns frozen or fresh time after a stop, after the pointer leaves the range, and after the halt flag is cleared.

// File: rtl/clkreg_shadow_ctrl.sv
module clkreg_shadow_ctrl #(
  parameter int NUM_REGS  = 20,
  parameter int CLK_REGS  = 8,
  parameter int DW        = 8,
  parameter int HALT_ADDR = 12,
  parameter int HALT_BIT  = 6,
  localparam int AW = $clog2(NUM_REGS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   bus_addr_ld,
  input  logic [AW-1:0]          bus_addr,
  input  logic                   bus_start,
  input  logic                   bus_rnw,
  input  logic                   bus_stop,
  input  logic                   bus_wr,
  input  logic [DW-1:0]          bus_wdata,
  input  logic                   bus_rd,
  output logic [DW-1:0]          rd_data,
  output logic [AW-1:0]          ptr,
  input  logic                   upd_tick,
  input  logic                   cnt_load,
  input  logic [CLK_REGS*DW-1:0] cnt_next,
  output logic [CLK_REGS*DW-1:0] int_time,
  input  logic                   pwr_fail,
  output logic                   halt_flag,
  output logic                   hold_active,
  output logic                   div_rst
);
  localparam int CW = $clog2(CLK_REGS);
  localparam logic [AW-1:0] CLK_LIM = AW'(CLK_REGS);
  localparam logic [AW-1:0] LAST    = AW'(NUM_REGS - 1);
  localparam logic [AW-1:0] HADDR   = AW'(HALT_ADDR);

  logic [DW-1:0] ureg [NUM_REGS];
  logic [DW-1:0] ireg [CLK_REGS];
  logic          rd_mode, pend;
  logic [DW-1:0] rd_byte;

  wire wr_en   = bus_wr & ~bus_addr_ld;
  wire clk_hit = ptr < CLK_LIM;
  wire blocked = hold_active | halt_flag;
  wire xfer    = (upd_tick | pend) & ~blocked;
  wire step    = (bus_rd | bus_wr) & ~bus_addr_ld;

  assign hold_active = rd_mode & clk_hit;

  for (genvar g = 0; g < CLK_REGS; g++) begin : g_out
    assign int_time[g*DW +: DW] = ireg[g];
  end

  always_comb begin
    rd_byte = ureg[ptr];
    if (ptr == HADDR) rd_byte[HALT_BIT] = halt_flag;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_REGS; i++) ureg[i] <= '0;
      for (int i = 0; i < CLK_REGS; i++) ireg[i] <= '0;
    end else begin
      if (xfer)
        for (int i = 0; i < CLK_REGS; i++) ureg[i] <= ireg[i];
      if (wr_en) ureg[ptr] <= bus_wdata;
      if (cnt_load)
        for (int i = 0; i < CLK_REGS; i++) ireg[i] <= cnt_next[i*DW +: DW];
      if (wr_en && clk_hit) ireg[ptr[CW-1:0]] <= bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr       <= '0;
      rd_mode   <= 1'b0;
      pend      <= 1'b0;
      halt_flag <= 1'b0;
      div_rst   <= 1'b0;
      rd_data   <= '0;
    end else begin
      if (bus_addr_ld)  ptr <= (bus_addr <= LAST) ? bus_addr : '0;
      else if (step)    ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;

      if (bus_stop)       rd_mode <= 1'b0;
      else if (bus_start) rd_mode <= bus_rnw;

      pend <= blocked & (pend | upd_tick);

      if (pwr_fail)                  halt_flag <= 1'b1;
      else if (wr_en && ptr == HADDR) halt_flag <= bus_wdata[HALT_BIT];

      div_rst <= wr_en & clk_hit;

      if (bus_rd && !bus_addr_ld) rd_data <= rd_byte;
    end
  end
endmodule

module clkreg_shadow_ctrl_chk #(
  parameter int NUM_REGS  = 20,
  parameter int CLK_REGS  = 8,
  parameter int DW        = 8,
  parameter int HALT_ADDR = 12,
  parameter int HALT_BIT  = 6,
  localparam int AW = $clog2(NUM_REGS)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_addr_ld,
  input logic          bus_stop,
  input logic          bus_wr,
  input logic          bus_rd,
  input logic [DW-1:0] bus_wdata,
  input logic [AW-1:0] ptr,
  input logic          pwr_fail,
  input logic          halt_flag,
  input logic          hold_active,
  input logic          div_rst
);
  localparam logic [AW-1:0] CLK_LIM = AW'(CLK_REGS);
  localparam logic [AW-1:0] LAST    = AW'(NUM_REGS - 1);
  localparam logic [AW-1:0] HADDR   = AW'(HALT_ADDR);

  // R8
  div_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    div_rst |-> $past(bus_wr && !bus_addr_ld && ptr < CLK_LIM));
  // R6
  halt_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_fail |=> halt_flag);
  // R7
  halt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_addr_ld && ptr == HADDR && !bus_wdata[HALT_BIT] && !pwr_fail) |=> !halt_flag);
  // R4
  hold_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_active |-> ptr < CLK_LIM);
  // R5
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_stop |=> !hold_active);
  // R3
  ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_rd || bus_wr) && !bus_addr_ld && ptr == LAST) |=> ptr == '0);
  // R3
  ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ptr <= LAST);
endmodule

bind clkreg_shadow_ctrl clkreg_shadow_ctrl_chk #(
  .NUM_REGS(NUM_REGS), .CLK_REGS(CLK_REGS), .DW(DW),
  .HALT_ADDR(HALT_ADDR), .HALT_BIT(HALT_BIT)
) u_chk (.*);

// File: tb/test_clkreg_shadow_ctrl.sv
module test_clkreg_shadow_ctrl;
  logic clk = 0, rst_n = 0;
  logic bus_addr_ld = 0, bus_start = 0, bus_rnw = 0, bus_stop = 0;
  logic bus_wr = 0, bus_rd = 0, upd_tick = 0, cnt_load = 0, pwr_fail = 0;
  logic [4:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [63:0] cnt_next = '0;
  logic [7:0] rd_data;
  logic [4:0] ptr;
  logic [63:0] int_time;
  logic halt_flag, hold_active, div_rst;
  int checks = 0, errors = 0;
  bit done = 0;

  clkreg_shadow_ctrl i_clkreg_shadow_ctrl (.*);

  always #10 clk = ~clk;

  // {addr, data, expect div_rst}
  localparam logic [13:0] VEC [6] = '{
    {5'h00, 8'h12, 1'b1}, {5'h07, 8'h99, 1'b1}, {5'h08, 8'hA5, 1'b0},
    {5'h0C, 8'h3F, 1'b0}, {5'h13, 8'h7E, 1'b0}, {5'h03, 8'h45, 1'b1}};

  localparam logic [63:0] PA = 64'h0807060504030201;
  localparam logic [63:0] PB = 64'h1817161514131211;
  localparam logic [63:0] PC = 64'h2827262524232221;
  localparam logic [63:0] PD = 64'h3837363534333231;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic set_addr(input logic [4:0] a);
    @(negedge clk); bus_addr_ld = 1; bus_addr = a;
    @(negedge clk); bus_addr_ld = 0;
  endtask
  task automatic start(input logic rnw);
    @(negedge clk); bus_start = 1; bus_rnw = rnw;
    @(negedge clk); bus_start = 0;
  endtask
  task automatic stop_t();
    @(negedge clk); bus_stop = 1;
    @(negedge clk); bus_stop = 0;
  endtask
  task automatic wr(input logic [7:0] d);
    @(negedge clk); bus_wr = 1; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask
  task automatic rd();
    @(negedge clk); bus_rd = 1;
    @(negedge clk); bus_rd = 0;
  endtask
  task automatic tick();
    @(negedge clk); upd_tick = 1;
    @(negedge clk); upd_tick = 0;
  endtask
  task automatic load(input logic [63:0] v);
    @(negedge clk); cnt_load = 1; cnt_next = v;
    @(negedge clk); cnt_load = 0;
  endtask
  task automatic read_at(input logic [4:0] a);
    set_addr(a); start(1); rd(); stop_t();
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 ptr", ptr, 0);
    chk("R1 halt", halt_flag, 0);
    chk("R1 hold", hold_active, 0);
    chk("R1 div_rst", div_rst, 0);
    chk("R1 rd_data", rd_data, 0);
    chk("R1 int_time", int_time, 0);
    rst_n = 1;

    // R2 full transfer, burst read
    load(PA);
    chk("R2 int_time", int_time, PA);
    tick();
    set_addr(0); start(1);
    chk("R4 hold on read", hold_active, 1);
    for (int i = 0; i < 8; i++) begin
      rd();
      chk("R2 burst byte", rd_data, PA[i*8 +: 8]);
    end
    chk("R3 ptr after burst", ptr, 8);
    chk("R5 hold off past range", hold_active, 0);
    stop_t();

    // R4 write transaction no hold
    set_addr(0); start(0);
    chk("R4 no hold on write", hold_active, 0);
    stop_t();

    // R4/R5 hold, release on stop
    set_addr(2); start(1); rd();
    chk("R4 hold mid read", hold_active, 1);
    load(PB); tick();
    rd();
    chk("R4 frozen byte", rd_data, 8'h04);
    stop_t();
    read_at(3);
    chk("R5 released by stop", rd_data, 8'h14);

    // R5 release by pointer leaving range
    set_addr(6); start(1); rd();
    load(PC); tick();
    rd();
    chk("R4 frozen byte 7", rd_data, 8'h18);
    chk("R5 hold drops at 08h", hold_active, 0);
    stop_t();
    read_at(0);
    chk("R5 released by range exit", rd_data, 8'h21);

    // R6 power fail halt
    @(negedge clk); pwr_fail = 1;
    @(negedge clk); pwr_fail = 0;
    chk("R6 halt set", halt_flag, 1);
    load(PD); tick();
    read_at(0);
    chk("R6 user copy frozen", rd_data, 8'h21);
    read_at(5'h0C);
    chk("R6 halt bit readable", rd_data, 8'h40);
    set_addr(5'h0C); start(0);
    @(negedge clk); bus_wr = 1; bus_wdata = 8'h00; pwr_fail = 1;
    @(negedge clk); bus_wr = 0; pwr_fail = 0;
    chk("R6 power fail beats write", halt_flag, 1);
    stop_t();

    // R7 clear halt, pending tick applies
    set_addr(5'h0C); start(0); wr(8'h00);
    chk("R7 halt cleared", halt_flag, 0);
    stop_t();
    read_at(0);
    chk("R7 current time shown", rd_data, 8'h31);
    read_at(6);
    chk("R7 current time byte 6", rd_data, 8'h37);

    // R8/R9 vector walk
    for (int i = 0; i < 6; i++) begin
      logic [4:0] a; logic [7:0] d; logic e;
      {a, d, e} = VEC[i];
      set_addr(a); start(0); wr(d);
      chk(e ? "R8 div_rst pulse" : "R9 no div_rst", div_rst, e);
      if (e) chk("R8 internal byte", int_time[a[2:0]*8 +: 8], d);
      stop_t();
      chk("R8 div_rst single cycle", div_rst, 0);
      read_at(a);
      chk(e ? "R8 user byte" : "R9 storage readback", rd_data, d);
    end

    // R3 wrap and out-of-range load
    set_addr(5'h12); start(1); rd(); rd();
    chk("R3 read at 13h", rd_data, 8'h7E);
    chk("R3 wrap to 00h", ptr, 0);
    stop_t();
    set_addr(5); set_addr(5'h1F);
    chk("R3 out-of-range load", ptr, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule